// File: doc/BRIEF.md
# Hardware Task Context Sequencer

This block steps a reconfigurable region through one hardware task built from a series of contexts. Software programs a frame base address and a context count through a small word-addressed register port, then sets a go bit. For each context the sequencer raises a start-of-context interrupt and requests a frame load from an external loader. When the loader finishes, it runs the fabric until the fabric reports the end of execution. It then raises a finish-of-context interrupt, releases the fabric for one cycle and records the completion in a status register.

Frames are laid out back to back in memory. Context k uses the frame at base plus k times a fixed frame size. When the programmed count of contexts has run, the sequencer parks in a done state and reports the whole task finished. It goes back to idle once software clears the go bit. A count of zero finishes the task at once, without loading anything. Each interrupt is a one-cycle pulse and is also held in a sticky status flag that software clears by writing one to it.

Top module: `ctx_sequencer`

## Requirements
- R1: After reset all handshake and interrupt outputs are low, and all three registers read zero.
- R2: While the go bit (CTRL bit 0) is 0 in the idle state, no interrupt, load request, execute or release is issued, whatever count is programmed.
- R3: One cycle after go is seen with a nonzero count (CTRL bits 15:8), irq_start pulses for exactly one cycle. The load request follows in the next cycle.
- R4: ld_req stays high, with ld_addr stable, until ld_done. For context k (counting from 0), ld_addr equals BASE + k*FRAME_BYTES.
- R5: ex_run rises in the cycle after ld_done and stays high until ex_done.
- R6: The cycle after ex_done, irq_finish pulses for one cycle. fab_release pulses in the cycle after that. The context-done bit (STAT bit 3) is then set and the completed count (STAT bits 15:8) goes up by one.
- R7: After exactly the programmed number of contexts the sequencer enters the done state, and the task-done bit (STAT bit 0) reads 1.
- R8: In the done state the sequencer stays put while go is 1. It returns to idle in the cycle after go reads 0.
- R9: STAT bit 1 latches irq_start and STAT bit 2 latches irq_finish. Writing 1 to either bit clears it.
- R10: A count of zero moves from idle straight to done. It loads no frame and raises no interrupt.
- R11: Outside the idle state, writes to the count field and to BASE are ignored, and clearing go does not stop the running task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 CTRL, 1 BASE, 2 STAT |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ld_req | output | 1 | Frame load request, held until ld_done |
| ld_addr | output | ADDR_W | Frame address for the current context |
| ld_done | input | 1 | Loader reports frame loaded |
| ex_run | output | 1 | Fabric execute enable |
| ex_done | input | 1 | Fabric reports end of execution |
| fab_release | output | 1 | One-cycle fabric release pulse |
| irq_start | output | 1 | Start-of-context interrupt pulse |
| irq_finish | output | 1 | Finish-of-context interrupt pulse |

## Verification
A wrong state or counter shows at the handshake ports within one cycle. An extra or missing interrupt pulse, a load request that drops before ld_done, or a frame address that skips a step are all visible there. A context counter that is off by one is caught when the task ends early or late, compared with the number of ld_done events, and again in the completed-count field. The bench keeps a behavioural model and compares every output and the addressed register each cycle, so a divergence is reported in the cycle it happens.

// File: rtl/ctx_sequencer.sv
module ctx_sequencer #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 8,
  parameter int FRAME_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ld_req,
  output logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_done,
  output logic              ex_run,
  input  logic              ex_done,
  output logic              fab_release,
  output logic              irq_start,
  output logic              irq_finish
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FRAME_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_CSTART, S_CFG, S_EXE, S_CFIN, S_RST, S_DONE
  } st_t;

  st_t              state, nstate;
  logic             go_q, flg_s, flg_f, ctx_done;
  logic [CNT_W-1:0] cnt_q, ctx_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0] ctx_inc;
  logic             wr_ctl, wr_base, wr_stat, idle;

  assign ctx_inc = ctx_q + 1'b1;
  assign idle    = (state == S_IDLE);
  assign wr_ctl  = reg_we && reg_addr == 2'd0;
  assign wr_base = reg_we && reg_addr == 2'd1 && idle;
  assign wr_stat = reg_we && reg_addr == 2'd2;

  always_comb begin
    nstate = state;
    unique case (state)
      S_IDLE:   if (go_q) nstate = (cnt_q == '0) ? S_DONE : S_CSTART;
      S_CSTART: nstate = S_CFG;
      S_CFG:    if (ld_done) nstate = S_EXE;
      S_EXE:    if (ex_done) nstate = S_CFIN;
      S_CFIN:   nstate = S_RST;
      S_RST:    nstate = (ctx_inc == cnt_q) ? S_DONE : S_CSTART;
      S_DONE:   if (!go_q) nstate = S_IDLE;
      default:  nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      go_q     <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      ctx_q    <= '0;
      ctx_done <= 1'b0;
      flg_s    <= 1'b0;
      flg_f    <= 1'b0;
    end else begin
      state <= nstate;
      if (wr_ctl) begin
        go_q <= reg_wdata[0];
        if (idle) cnt_q <= reg_wdata[8 +: CNT_W];
      end
      if (wr_base) base_q <= reg_wdata[ADDR_W-1:0];
      if (idle && go_q) begin
        ctx_q    <= '0;
        ctx_done <= 1'b0;
      end
      if (state == S_CSTART) ctx_done <= 1'b0;
      if (state == S_RST) begin
        ctx_done <= 1'b1;
        ctx_q    <= ctx_inc;
      end
      if (state == S_CSTART)             flg_s <= 1'b1;
      else if (wr_stat && reg_wdata[1])  flg_s <= 1'b0;
      if (state == S_CFIN)               flg_f <= 1'b1;
      else if (wr_stat && reg_wdata[2])  flg_f <= 1'b0;
    end
  end

  assign irq_start   = (state == S_CSTART);
  assign ld_req      = (state == S_CFG);
  assign ex_run      = (state == S_EXE);
  assign irq_finish  = (state == S_CFIN);
  assign fab_release = (state == S_RST);
  assign ld_addr     = base_q + ADDR_W'(ctx_q) * STEP;

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = (32'(cnt_q) << 8) | 32'(go_q);
      2'd1:    reg_rdata = 32'(base_q);
      2'd2:    reg_rdata = (32'(ctx_q) << 8) |
                           {28'd0, ctx_done, flg_f, flg_s, state == S_DONE};
      default: reg_rdata = 32'd0;
    endcase
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_start |=> !irq_start && ld_req);

  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && !ld_done |=> ld_req && $stable(ld_addr));

  // R5
  exec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && ld_done |=> ex_run);

  // R6
  finish_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_finish |=> fab_release && !irq_finish);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DONE && go_q |=> state == S_DONE);

  // R10
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && go_q && cnt_q == '0 |=> state == S_DONE && !irq_start);
endmodule

// File: tb/test_ctx_sequencer.sv
module test_ctx_sequencer;
  localparam int FRAME = 4096;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        ld_req, ld_done = 0, ex_run, ex_done = 0;
  logic        fab_release, irq_start, irq_finish;
  logic [31:0] ld_addr;

  ctx_sequencer i_ctx_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ld_req(ld_req),
    .ld_addr(ld_addr), .ld_done(ld_done), .ex_run(ex_run), .ex_done(ex_done),
    .fab_release(fab_release), .irq_start(irq_start), .irq_finish(irq_finish));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int loads = 0, n_irq_s = 0, ld_lat = 2, ex_lat = 3, ld_cnt = 0, ex_cnt = 0;
  logic [31:0] addr_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int ms = 0, m_k = 0;
  bit m_go = 0, m_sf = 0, m_ff = 0, m_cd = 0;
  logic [7:0]  m_cnt = 0;
  logic [31:0] m_base = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; m_k = 0; m_go = 0; m_sf = 0; m_ff = 0; m_cd = 0; m_cnt = 0; m_base = 0;
    end else begin
      int ns = ms, nk = m_k;
      bit ngo = m_go, nsf = m_sf, nff = m_ff, ncd = m_cd;
      logic [7:0] ncnt = m_cnt;
      logic [31:0] nbase = m_base;
      case (ms)
        0: if (m_go) begin nk = 0; ncd = 0; ns = (m_cnt == 0) ? 6 : 1; end
        1: begin ns = 2; ncd = 0; end
        2: if (ld_done) ns = 3;
        3: if (ex_done) ns = 4;
        4: ns = 5;
        5: begin ncd = 1; nk = m_k + 1; ns = (m_k + 1 == int'(m_cnt)) ? 6 : 1; end
        6: if (!m_go) ns = 0;
        default: ns = 0;
      endcase
      if (reg_we && reg_addr == 0) begin ngo = reg_wdata[0]; if (ms == 0) ncnt = reg_wdata[15:8]; end
      if (reg_we && reg_addr == 1 && ms == 0) nbase = reg_wdata;
      if (ms == 1) nsf = 1; else if (reg_we && reg_addr == 2 && reg_wdata[1]) nsf = 0;
      if (ms == 4) nff = 1; else if (reg_we && reg_addr == 2 && reg_wdata[2]) nff = 0;
      ms = ns; m_k = nk; m_go = ngo; m_sf = nsf; m_ff = nff; m_cd = ncd; m_cnt = ncnt; m_base = nbase;
    end
  end

  function automatic logic [31:0] m_rd(input logic [1:0] a);
    case (a)
      0: return {16'd0, m_cnt, 7'd0, m_go};
      1: return m_base;
      2: return {16'd0, 8'(m_k), 4'd0, m_cd, m_ff, m_sf, ms == 6};
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      if (irq_start) n_irq_s++;
      chk(irq_start == (ms == 1), "R3 irq_start", irq_start, ms == 1);
      chk(ld_req == (ms == 2), "R4 ld_req", ld_req, ms == 2);
      chk(ld_addr == m_base + m_k * FRAME, "R4 ld_addr", ld_addr, m_base + m_k * FRAME);
      chk(ex_run == (ms == 3), "R5 ex_run", ex_run, ms == 3);
      chk(irq_finish == (ms == 4), "R6 irq_finish", irq_finish, ms == 4);
      chk(fab_release == (ms == 5), "R6 fab_release", fab_release, ms == 5);
      chk(reg_rdata == m_rd(reg_addr), "R9 reg_rdata", reg_rdata, m_rd(reg_addr));
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // loader and fabric responders
  always @(negedge clk) begin
    if (ld_done) ld_done = 0;
    else if (ld_req) begin
      if (ld_cnt >= ld_lat) begin
        ld_done = 1; ld_cnt = 0; loads++; addr_q.push_back(ld_addr);
      end else ld_cnt++;
    end else ld_cnt = 0;
  end

  always @(negedge clk) begin
    if (ex_done) ex_done = 0;
    else if (ex_run) begin
      if (ex_cnt >= ex_lat) begin ex_done = 1; ex_cnt = 0; end
      else ex_cnt++;
    end else ex_cnt = 0;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(2, v);
      if (v[0]) return;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(!ld_req && !ex_run && !irq_start && !irq_finish && !fab_release, "R1 outputs", 0, 0);
    rst_n = 1;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v); chk(v == 0, "R1 register", v, 0);
    end

    // R2: count programmed, go low
    wr(0, 32'h0000_0300);
    repeat (8) @(negedge clk);
    chk(loads == 0 && n_irq_s == 0, "R2 idle hold", loads, 0);

    // three contexts
    wr(1, 32'h1000_0000);
    addr_q.delete(); loads = 0;
    wr(0, 32'h0000_0301);
    wait_done();
    chk(loads == 3, "R7 load count", loads, 3);
    for (int k = 0; k < 3; k++)
      chk(addr_q[k] == 32'h1000_0000 + k * FRAME, "R4 frame address", addr_q[k], 32'h1000_0000 + k * FRAME);
    rd(2, v);
    chk(v[15:8] == 3 && v[3], "R6 completion", v, 32'h30f);
    chk(v[2:1] == 2'b11, "R9 latched flags", v[2:1], 3);
    wr(2, 32'h6);
    rd(2, v); chk(v[2:1] == 0, "R9 write-one clear", v[2:1], 0);
    repeat (5) @(negedge clk);
    rd(2, v); chk(v[0] == 1, "R8 done held", v[0], 1);
    wr(0, 32'h0000_0300);
    @(negedge clk);
    rd(2, v); chk(v[0] == 0, "R8 back to idle", v[0], 0);

    // one context, zero latency
    ld_lat = 0; ex_lat = 0; addr_q.delete(); loads = 0;
    wr(1, 32'h2000_4000);
    wr(0, 32'h0000_0101);
    wait_done();
    chk(loads == 1 && addr_q[0] == 32'h2000_4000, "R4 single context", addr_q[0], 32'h2000_4000);
    wr(0, 32'h0000_0100);

    // R11: writes ignored while busy
    ld_lat = 20; ex_lat = 20; addr_q.delete(); loads = 0;
    wr(1, 32'h3000_0000);
    wr(0, 32'h0000_0201);
    repeat (4) @(negedge clk);
    wr(1, 32'hdead_0000);
    wr(0, 32'h0000_0701);
    wr(0, 32'h0000_0700);
    repeat (150) @(negedge clk);
    chk(loads == 2, "R11 task ran to end", loads, 2);
    chk(addr_q[1] == 32'h3000_0000 + FRAME, "R11 base kept", addr_q[1], 32'h3000_0000 + FRAME);
    rd(1, v); chk(v == 32'h3000_0000, "R11 BASE read", v, 32'h3000_0000);
    rd(0, v); chk(v[15:8] == 2 && !v[0], "R11 CTRL read", v, 32'h200);
    rd(2, v); chk(v[0] == 0 && v[15:8] == 2, "R8 idle after go cleared", v, 32'h200);

    // R10: zero contexts
    loads = 0; n_irq_s = 0;
    wr(0, 32'h0000_0001);
    @(negedge clk);
    rd(2, v); chk(v[0] == 1, "R10 straight to done", v[0], 1);
    chk(loads == 0 && n_irq_s == 0, "R10 no load", loads, 0);
    wr(0, 32'h0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule